// File: doc/BRIEF.md
# Wired Interrupt to MSI Generator

The block turns a bank of wired interrupt lines into message-signalled interrupts. Software programs a device ID and an event ID for each line through a word-addressed register port. It also selects whether the line fires on a rising edge or while its level is high. A line that fires latches a pending flag. A round-robin arbiter then emits exactly one message for that line on a valid/ready output, and the message carries the line's device and event IDs. The line stays silent until software writes its bit in the clear registers.

Pin numbers below 64 are reserved and have no input. Input bit k of `irq_i` is pin 64+k. Pins are grouped 128 to a node, and node n (counting from 1) owns the 4 KiB window that starts at n×0x1000. The clear registers are one global bank at 0xA000, indexed by absolute pin number. The default build has two nodes, which gives pins 64 to 319.

Top module: `wire_msi_gen`

## Requirements
- R1: Pin p (local index k = p−64) has a vector register at byte address n×0x1000 + 0x200 + 4×(k mod 128), where n = k/128 + 1. Bits [21:12] hold the event ID and bits [11:0] hold the device ID. Bits [31:22] read 0. A read-modify-write that changes only the event field keeps the device field. Every message carries the values of that register.
- R2: Trigger-type words sit at n×0x1000 + 4×((k mod 128)/32), and bit (k mod 32) belongs to pin p. A 1 selects level-high and a 0 selects rising-edge. The words read back what was written.
- R3: A rising-edge pin becomes pending on a 0-to-1 change of its synchronised input and sends one message. An input that stays high sends nothing more, even after a clear.
- R4: A level-high pin becomes pending while its input is high. If its input is still high after a clear, it becomes pending again and sends another message.
- R5: A pending pin sends exactly one message. Edges that arrive before its clear are dropped.
- R6: Writing 1 to bit (p mod 32) of the word at 0xA000 + 4×(p/32) clears pin p. Reading that word returns the pending flags of those 32 pins.
- R7: Pending pins that have not yet sent are served round-robin. The search starts at the pin just after the last one granted.
- R8: While `msg_valid_o` is high and `msg_ready_i` is low, the valid signal and both IDs stay unchanged.
- R9: The following addresses read 0 and ignore writes: reserved pins 0–63 (clear words 0 and 1), node 0, nodes beyond the configured count, clear words beyond the last pin, and unused offsets inside a node window.
- R10: After reset, `msg_valid_o` is low and all vector, type and pending state is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 16 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_i | input | 256 | Wired lines; bit k is pin 64+k |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted by downstream |
| msg_dev_o | output | 12 | Device ID of message |
| msg_evt_o | output | 10 | Event ID of message |

## Verification
All 256 vector registers are written and read back with junk in the upper bits. Each pin gets a distinct event ID, so every message can be traced to its pin and its device ID can be checked. The bench drives a sparse edge-mode set and a different level-mode set. With the inputs held high, cleared, and toggled, edge mode stays silent where level mode re-sends, and toggles before a clear are dropped. A two-pin race placed on either side of the last grant distinguishes round-robin from fixed priority. The same race, run with ready held low, shows that the output holds its values.

// File: rtl/wmsi_pkg.sv
package wmsi_pkg;
  localparam int PIN_BASE      = 64;
  localparam int PINS_PER_NODE = 128;
  localparam int WORD_PINS     = 32;
  localparam int DEV_W         = 12;
  localparam int EVT_W         = 10;
  localparam logic [3:0] CLR_PAGE = 4'hA;

  typedef struct packed {
    logic [EVT_W-1:0] evt;
    logic [DEV_W-1:0] dev;
  } vec_t;
endpackage

// File: rtl/wmsi_detect.sv
module wmsi_detect #(
  parameter int NPIN = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] irq_i,
  input  logic [NPIN-1:0] lvl_i,
  output logic [NPIN-1:0] trig_o
);
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= irq_i[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign trig_o[g] = lvl_i[g] ? s2_q : (s2_q & ~prev_q);
  end
endmodule

// File: rtl/wmsi_regs.sv
module wmsi_regs
  import wmsi_pkg::*;
#(
  parameter int NUM_NODES = 2,
  parameter int NPIN      = NUM_NODES * PINS_PER_NODE
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [15:0]     addr_i,
  input  logic [31:0]     wdata_i,
  input  logic [NPIN-1:0] pend_i,
  output vec_t            vec_o [NPIN],
  output logic [NPIN-1:0] lvl_o,
  output logic [NPIN-1:0] clr_o,
  output logic [31:0]     rdata_o
);
  localparam int IDX_W = $clog2(NPIN);

  logic [3:0]  node;
  logic [11:0] off;
  logic [9:0]  cw;
  logic        in_node, is_type, is_vec, is_clr;
  int          node_base, vec_idx, type_lo, clr_lo;

  assign node = addr_i[15:12];
  assign off  = addr_i[11:0];
  assign cw   = addr_i[11:2];

  always_comb begin
    in_node   = (node != 4'd0) && (int'(node) <= NUM_NODES);
    is_type   = in_node && (off[11:4] == 8'd0);
    is_vec    = in_node && (off[11:9] == 3'b001);
    is_clr    = (node == CLR_PAGE) && (int'(cw) >= PIN_BASE / WORD_PINS)
                && (int'(cw) < (PIN_BASE + NPIN) / WORD_PINS);
    node_base = (int'(node) - 1) * PINS_PER_NODE;
    vec_idx   = node_base + int'(off[8:2]);
    type_lo   = node_base + int'(off[3:2]) * WORD_PINS;
    clr_lo    = int'(cw) * WORD_PINS - PIN_BASE;
  end

  vec_t            vec_q [NPIN];
  logic [NPIN-1:0] lvl_q;

  for (genvar g = 0; g < NPIN; g++) begin : g_vec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vec_q[g] <= '0;
      else if (wr_en_i && is_vec && vec_idx == g)
        vec_q[g] <= vec_t'({wdata_i[21:12], wdata_i[11:0]});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else if (wr_en_i && is_type)
      lvl_q[IDX_W'(type_lo) +: WORD_PINS] <= wdata_i;
  end

  always_comb begin
    clr_o = '0;
    if (wr_en_i && is_clr) clr_o[IDX_W'(clr_lo) +: WORD_PINS] = wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (is_vec)       rdata_o = {10'd0, vec_q[IDX_W'(vec_idx)]};
    else if (is_type) rdata_o = lvl_q[IDX_W'(type_lo) +: WORD_PINS];
    else if (is_clr)  rdata_o = pend_i[IDX_W'(clr_lo) +: WORD_PINS];
  end

  assign vec_o = vec_q;
  assign lvl_o = lvl_q;

  a_r9_reserved_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:12] == CLR_PAGE && addr_i[11:3] == 9'd0) |-> rdata_o == 32'd0);
  a_r9_node0_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[15:12] == 4'd0) |=> $stable(lvl_q));
  a_r1_vec_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:12] == 4'd1 && addr_i[11:9] == 3'b001) |-> rdata_o[31:22] == 10'd0);
endmodule

// File: rtl/wmsi_rr_arb.sv
module wmsi_rr_arb #(
  parameter int NPIN  = 256,
  parameter int IDX_W = $clog2(NPIN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPIN-1:0]  req_i,
  input  logic             take_i,
  output logic             gnt_any_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    int j;
    gnt_any_o = 1'b0;
    gnt_idx_o = '0;
    for (int i = 0; i < NPIN; i++) begin
      j = (int'(ptr_q) + i) % NPIN;
      if (!gnt_any_o && req_i[j]) begin
        gnt_any_o = 1'b1;
        gnt_idx_o = IDX_W'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (take_i && gnt_any_o) ptr_q <= IDX_W'((int'(gnt_idx_o) + 1) % NPIN);
  end

  a_r7_grant_is_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_any_o |-> req_i[gnt_idx_o]);
  a_r7_no_idle_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> gnt_any_o);
endmodule

// File: rtl/wire_msi_gen.sv
module wire_msi_gen
  import wmsi_pkg::*;
#(
  parameter int NUM_NODES = 2,
  parameter int NPIN      = NUM_NODES * PINS_PER_NODE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [15:0]      addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [NPIN-1:0]  irq_i,
  output logic             msg_valid_o,
  input  logic             msg_ready_i,
  output logic [DEV_W-1:0] msg_dev_o,
  output logic [EVT_W-1:0] msg_evt_o
);
  localparam int IDX_W = $clog2(NPIN);

  vec_t             vec [NPIN];
  logic [NPIN-1:0]  lvl, clr, trig, pend_q, sent_q, cand, sent_set;
  logic             load, gnt_any;
  logic [IDX_W-1:0] gnt_idx;

  wmsi_regs #(.NUM_NODES(NUM_NODES), .NPIN(NPIN)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .pend_i(pend_q), .vec_o(vec), .lvl_o(lvl), .clr_o(clr), .rdata_o
  );

  wmsi_detect #(.NPIN(NPIN)) u_det (
    .clk_i, .rst_ni, .irq_i, .lvl_i(lvl), .trig_o(trig)
  );

  assign cand = pend_q & ~sent_q;
  assign load = !msg_valid_o || msg_ready_i;

  wmsi_rr_arb #(.NPIN(NPIN), .IDX_W(IDX_W)) u_arb (
    .clk_i, .rst_ni, .req_i(cand), .take_i(load),
    .gnt_any_o(gnt_any), .gnt_idx_o(gnt_idx)
  );

  always_comb begin
    sent_set = '0;
    if (load && gnt_any) sent_set[gnt_idx] = 1'b1;
  end

  // clear has priority over a same-cycle trigger
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      sent_q <= '0;
    end else begin
      pend_q <= (pend_q | trig) & ~clr;
      sent_q <= (sent_q | sent_set) & ~clr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o <= 1'b0;
      msg_dev_o   <= '0;
      msg_evt_o   <= '0;
    end else if (load) begin
      msg_valid_o <= gnt_any;
      if (gnt_any) begin
        msg_dev_o <= vec[gnt_idx].dev;
        msg_evt_o <= vec[gnt_idx].evt;
      end
    end
  end

  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=>
      (msg_valid_o && $stable(msg_dev_o) && $stable(msg_evt_o)));
  a_r5_sent_only_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sent_q & ~pend_q) == '0);
  a_r6_pending_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pend_q) & ~$past(clr)) & ~pend_q) == '0));
endmodule

// File: tb/wire_msi_gen_tb.sv
`timescale 1ns/1ps
module wire_msi_gen_tb;
  localparam int NP = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [15:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] irq = '0;
  logic          m_valid;
  logic          m_ready = 1'b1;
  logic [11:0]   m_dev;
  logic [9:0]    m_evt;

  int cmp = 0, mis = 0;
  int cnt [NP];
  int exp_cnt [NP];
  int log_evt [0:4095];
  int log_n = 0;

  always #2 clk = ~clk;

  wire_msi_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_i(irq), .msg_valid_o(m_valid), .msg_ready_i(m_ready),
    .msg_dev_o(m_dev), .msg_evt_o(m_evt)
  );

  function automatic logic [11:0] dev_of(int k);
    return 12'((k * 37 + 5) & 12'hFFF);
  endfunction
  function automatic logic [15:0] vaddr(int k);
    return 16'((k / 128 + 1) * 4096 + 16'h200 + 4 * (k % 128));
  endfunction
  function automatic logic [15:0] taddr(int k);
    return 16'((k / 128 + 1) * 4096 + 4 * ((k % 128) / 32));
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    cmp++;
    if (act !== exp) begin
      mis++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wr_en = 1'b0;
    #1 d = rdata;
  endtask

  task automatic rd_chk(string r, logic [15:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(r, d, exp);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_all();
    for (int w = 2; w < 10; w++) wr(16'(16'hA000 + 4 * w), 32'hFFFF_FFFF);
  endtask

  task automatic chk_counts(string r);
    for (int k = 0; k < NP; k++) chk(r, 32'(cnt[k]), 32'(exp_cnt[k]));
  endtask

  // handshake occurs at the next posedge; inputs change only at posedge+1
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      cnt[m_evt]++;
      log_evt[log_n % 4096] = int'(m_evt);
      log_n++;
      chk("R1 message device id", 32'(m_dev), 32'(dev_of(int'(m_evt))));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    mis++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmp, mis);
    $finish;
  end

  initial begin
    logic [31:0] d, e;
    logic [NP-1:0] sset, lset;
    for (int k = 0; k < NP; k++) begin
      cnt[k] = 0;
      exp_cnt[k] = 0;
      sset[k] = (k % 7 == 3);
      lset[k] = (k % 11 == 4);
    end
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R10 reset state
    chk("R10 valid after reset", 32'(m_valid), 32'd0);
    rd_chk("R10 vector zero", vaddr(0), 32'd0);
    rd_chk("R10 vector zero", vaddr(255), 32'd0);
    rd_chk("R10 type zero", taddr(130), 32'd0);
    rd_chk("R10 pending zero", 16'hA008, 32'd0);

    // R1 vector registers, junk in upper bits
    for (int k = 0; k < NP; k++) wr(vaddr(k), 32'hFFC0_0000 | (32'(k) << 12) | 32'(dev_of(k)));
    for (int k = 0; k < NP; k++) rd_chk("R1 vector readback", vaddr(k), (32'(k) << 12) | 32'(dev_of(k)));
    foreach (d[i]) ;
    for (int t = 0; t < 2; t++) begin
      int k = (t == 0) ? 0 : 200;
      rd(vaddr(k), d);
      d = (d & ~(32'h3FF << 12)) | (32'h2AB << 12);
      wr(vaddr(k), d);
      rd_chk("R1 rmw keeps device id", vaddr(k), (32'h2AB << 12) | 32'(dev_of(k)));
      wr(vaddr(k), (32'(k) << 12) | 32'(dev_of(k)));
    end

    // R9 unmapped and reserved
    wr(16'h0200, 32'hFFFF_FFFF);
    wr(16'h0000, 32'hFFFF_FFFF);
    wr(16'h3000, 32'hFFFF_FFFF);
    wr(16'h3200, 32'hFFFF_FFFF);
    wr(16'h1100, 32'hFFFF_FFFF);
    wr(16'hA000, 32'hFFFF_FFFF);
    wr(16'hA028, 32'hFFFF_FFFF);
    rd_chk("R9 node0 vector", 16'h0200, 32'd0);
    rd_chk("R9 node0 type", 16'h0000, 32'd0);
    rd_chk("R9 node3 type", 16'h3000, 32'd0);
    rd_chk("R9 node3 vector", 16'h3200, 32'd0);
    rd_chk("R9 gap in node", 16'h1100, 32'd0);
    rd_chk("R9 gap in node", 16'h1010, 32'd0);
    rd_chk("R9 reserved clear word0", 16'hA000, 32'd0);
    rd_chk("R9 reserved clear word1", 16'hA004, 32'd0);
    rd_chk("R9 clear beyond pins", 16'hA028, 32'd0);
    rd_chk("R9 mapped vector untouched", vaddr(0), 32'(dev_of(0)));
    rd_chk("R9 mapped type untouched", taddr(0), 32'd0);
    rd_chk("R9 mapped type untouched", taddr(128), 32'd0);
    wait_cyc(20);
    chk("R9 no message from writes", 32'(log_n), 32'd0);

    // R3 edge mode
    irq = sset;
    wait_cyc(400);
    for (int k = 0; k < NP; k++) if (sset[k]) exp_cnt[k]++;
    chk_counts("R3 one message per edge");
    for (int w = 2; w < 10; w++) begin
      e = '0;
      for (int b = 0; b < 32; b++) e[b] = sset[w * 32 + b - 64];
      rd_chk("R6 pending readback", 16'(16'hA000 + 4 * w), e);
    end
    irq = '0;
    wait_cyc(10);
    irq = sset;
    wait_cyc(400);
    chk_counts("R5 edges while pending dropped");
    clear_all();
    for (int w = 2; w < 10; w++) rd_chk("R6 clear empties pending", 16'(16'hA000 + 4 * w), 32'd0);
    wait_cyc(100);
    chk_counts("R3 held edge input no resend");
    irq = '0;
    wait_cyc(10);
    irq = sset;
    wait_cyc(400);
    for (int k = 0; k < NP; k++) if (sset[k]) exp_cnt[k]++;
    chk_counts("R3 new edge after clear");
    irq = '0;
    wait_cyc(10);
    clear_all();

    // R2 / R4 level mode
    for (int k = 0; k < NP; k += 32) begin
      e = '0;
      for (int b = 0; b < 32; b++) e[b] = lset[k + b];
      wr(taddr(k), e);
    end
    for (int k = 0; k < NP; k += 32) begin
      e = '0;
      for (int b = 0; b < 32; b++) e[b] = lset[k + b];
      rd_chk("R2 type readback", taddr(k), e);
    end
    wait_cyc(20);
    chk_counts("R2 type write alone sends nothing");
    irq = lset;
    wait_cyc(400);
    for (int k = 0; k < NP; k++) if (lset[k]) exp_cnt[k]++;
    chk_counts("R4 level pends");
    clear_all();
    wait_cyc(400);
    for (int k = 0; k < NP; k++) if (lset[k]) exp_cnt[k]++;
    chk_counts("R4 level still high resends");
    irq = '0;
    wait_cyc(10);
    clear_all();
    wait_cyc(200);
    chk_counts("R4 level low stays quiet");
    for (int k = 0; k < NP; k += 32) wr(taddr(k), 32'd0);

    // R7 round robin and R8 hold
    irq[100] = 1'b1;
    wait_cyc(50);
    chk("R7 single grant", 32'(log_evt[(log_n - 1) % 4096]), 32'd100);
    m_ready = 1'b0;
    irq[50] = 1'b1;
    irq[150] = 1'b1;
    wait_cyc(50);
    chk("R8 valid held", 32'(m_valid), 32'd1);
    chk("R7 rotation picks above last grant", 32'(m_evt), 32'd150);
    for (int i = 0; i < 5; i++) begin
      wait_cyc(2);
      chk("R8 valid stable", 32'(m_valid), 32'd1);
      chk("R8 event stable", 32'(m_evt), 32'd150);
      chk("R8 device stable", 32'(m_dev), 32'(dev_of(150)));
    end
    m_ready = 1'b1;
    wait_cyc(30);
    chk("R7 first served", 32'(log_evt[(log_n - 2) % 4096]), 32'd150);
    chk("R7 second served", 32'(log_evt[(log_n - 1) % 4096]), 32'd50);
    chk("R5 no extra sends", 32'(cnt[50] + cnt[150]), 32'(exp_cnt[50] + exp_cnt[150] + 2));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmp, mis);
    $finish;
  end
endmodule